// File: doc/BRIEF.md
# Three-form instruction decoder

This block turns one 16-bit instruction word of a 32-bit, sixteen-register processor into the control fields that the later stages need. The word arrives as two fetched bytes. The byte from the lower address holds the upper half of the word. The decoder finds which of three encoding layouts the word uses, taken from its two top bits. It then pulls out the opcode and register indices, or the 8-bit immediate, or the branch displacement, depending on the layout. It also reports whether a 32-bit immediate follows in the instruction stream, which makes the instruction 6 bytes long instead of 2, and it raises a flag for encodings that name no instruction.

The decode logic is purely combinational. Its result is captured in one output register whenever the input valid is high, and a valid strobe comes out one cycle later. Executing the instruction, accessing memory and gathering the trailing 32-bit word all belong to other blocks.

Top module: `insn_decoder`

## Requirements
- R1: The instruction word is `{byteLo, byteHi}`, so `byteLo` (the lower-address byte) supplies bits 15:8.
- R2: `form` reports the layout as 1 when bit 15 is 0, as 2 when bits 15:14 are 10, and as 3 when bits 15:14 are 11.
- R3: In layout 1, `opcode` is bits 15:8, `regA` is bits 7:4 and `regB` is bits 3:0. `imm8` and `brOffset` are zero.
- R4: In layout 2, `opcode` is bits 13:12 zero-extended (0 = add immediate, 1 = subtract immediate, 2 = read special register, 3 = write special register), `regA` is bits 11:8 and `imm8` is bits 7:0, which is the special-register index for codes 2 and 3. `regB` and `brOffset` are zero.
- R5: In layout 3, `opcode` is bits 13:10 zero-extended and `brOffset` is bits 9:0 taken as a signed value, multiplied by two and sign-extended to 32 bits. `regA`, `regB` and `imm8` are zero.
- R6: A layout-1 word whose opcode is one of 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30, 0x36, 0x37, 0x38 or 0x39 sets `hasLongImm` and gives `instrLen` = 6. Every other word clears `hasLongImm` and gives `instrLen` = 2.
- R7: Layout-2 and layout-3 words never set `hasLongImm` and always give `instrLen` = 2.
- R8: `illegal` is set for layout-1 opcode 0x00, for layout-1 opcodes above 0x39 and for layout-3 opcodes above 9. It is never set for layout 2.
- R9: `outValid` equals `inValid` delayed by one clock. The output fields take the decode of the bytes present on a clock edge where `inValid` is high, and they hold their value across edges where it is low.
- R10: While `rstN` is low, `outValid` and every output field are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | The bytes are a word to decode |
| byteLo | input | 8 | Lower-address byte, word bits 15:8 |
| byteHi | input | 8 | Higher-address byte, word bits 7:0 |
| outValid | output | 1 | Registered fields are fresh this cycle |
| form | output | 2 | Layout code 1, 2 or 3 |
| opcode | output | 8 | Opcode, zero-extended |
| regA | output | 4 | First register index |
| regB | output | 4 | Second register index |
| imm8 | output | 8 | Short immediate or special-register index |
| brOffset | output | 32 | Signed branch displacement in bytes |
| hasLongImm | output | 1 | A 32-bit immediate word follows |
| instrLen | output | 3 | Instruction length in bytes, 2 or 6 |
| illegal | output | 1 | The encoding is undefined |

## Verification
The hardest cases to reach are the edges of the legal opcode ranges and the long-immediate set scattered through layout 1. Next to them sit the sign boundary of the 10-bit displacement, where bit 9 flips the sign of all 32 output bits. Random stimulus would hit these edges only rarely. The bench therefore drives all 65536 words back to back, one per cycle, and checks each decode against values it works out arithmetically from the word. A final phase drops the input valid while it changes the bytes, which shows that the fields hold.

// File: rtl/insn_decoder_pkg.sv
package insn_decoder_pkg;

  localparam int WORD_W   = 32;
  localparam int OP_W     = 8;
  localparam int REG_W    = 4;
  localparam int IMM8_W   = 8;
  localparam int OFF_W    = 10;
  localparam int LEN_W    = 3;
  localparam logic [LEN_W-1:0] LEN_SHORT = 3'd2;
  localparam logic [LEN_W-1:0] LEN_LONG  = 3'd6;

  typedef enum logic [1:0] {
    FORM_NONE  = 2'd0,
    FORM_ONE   = 2'd1,
    FORM_TWO   = 2'd2,
    FORM_THREE = 2'd3
  } formE;

  // layout-2 operation codes
  typedef enum logic [1:0] {
    SHORT_ADD   = 2'd0,
    SHORT_SUB   = 2'd1,
    SPECIAL_RD  = 2'd2,
    SPECIAL_WR  = 2'd3
  } shortOpE;

  typedef struct packed {
    formE               form;
    logic [OP_W-1:0]    opcode;
    logic [REG_W-1:0]   regA;
    logic [REG_W-1:0]   regB;
    logic [IMM8_W-1:0]  imm8;
    logic [WORD_W-1:0]  brOffset;
    logic               longImm;
    logic [LEN_W-1:0]   len;
    logic               illegal;
  } decT;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
  } ctrlStrobeT;

  function automatic logic isLongOp(input logic [OP_W-1:0] op);
    case (op)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D,
      8'h1A, 8'h1B, 8'h1D, 8'h1F, 8'h20, 8'h22,
      8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39: return 1'b1;
      default:                                   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/insn_decoder_classify.sv
module insn_decoder_classify
  import insn_decoder_pkg::*;
#(
  parameter logic [OP_W-1:0] F1_LAST_OP = 8'h39,
  parameter logic [3:0]      F3_LAST_OP = 4'd9
) (
  input  logic [7:0] byteLo,
  input  logic [7:0] byteHi,
  output decT        decoded
);

  localparam int EXT_W = WORD_W - OFF_W - 1;

  logic [15:0] word;
  assign word = {byteLo, byteHi};

  always_comb begin
    decoded = '0;
    if (!word[15]) begin
      decoded.form    = FORM_ONE;
      decoded.opcode  = word[15:8];
      decoded.regA    = word[7:4];
      decoded.regB    = word[3:0];
      decoded.longImm = isLongOp(word[15:8]);
      decoded.illegal = (word[15:8] == '0) || (word[15:8] > F1_LAST_OP);
    end else if (!word[14]) begin
      decoded.form    = FORM_TWO;
      decoded.opcode  = {{(OP_W-2){1'b0}}, word[13:12]};
      decoded.regA    = word[11:8];
      decoded.imm8    = word[7:0];
    end else begin
      decoded.form     = FORM_THREE;
      decoded.opcode   = {{(OP_W-4){1'b0}}, word[13:10]};
      decoded.brOffset = {{EXT_W{word[OFF_W-1]}}, word[OFF_W-1:0], 1'b0};
      decoded.illegal  = word[13:10] > F3_LAST_OP;
    end
    decoded.len = decoded.longImm ? LEN_LONG : LEN_SHORT;
  end

endmodule

// File: rtl/insn_decoder_ctrl.sv
module insn_decoder_ctrl
  import insn_decoder_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output ctrlStrobeT strobe,
  output logic       outValid
);

  assign strobe.capture = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/insn_decoder_datapath.sv
module insn_decoder_datapath
  import insn_decoder_pkg::*;
#(
  parameter logic [OP_W-1:0] F1_LAST_OP = 8'h39,
  parameter logic [3:0]      F3_LAST_OP = 4'd9
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStrobeT strobe,
  input  logic [7:0] byteLo,
  input  logic [7:0] byteHi,
  output decT        held
);

  decT decoded;

  insn_decoder_classify #(
    .F1_LAST_OP(F1_LAST_OP),
    .F3_LAST_OP(F3_LAST_OP)
  ) u_classify (
    .byteLo (byteLo),
    .byteHi (byteHi),
    .decoded(decoded)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              held <= '0;
    else if (strobe.capture) held <= decoded;
  end

endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_decoder_pkg::*;
#(
  parameter logic [7:0] F1_LAST_OP = 8'h39,
  parameter logic [3:0] F3_LAST_OP = 4'd9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [7:0]  byteLo,
  input  logic [7:0]  byteHi,
  output logic        outValid,
  output logic [1:0]  form,
  output logic [7:0]  opcode,
  output logic [3:0]  regA,
  output logic [3:0]  regB,
  output logic [7:0]  imm8,
  output logic [31:0] brOffset,
  output logic        hasLongImm,
  output logic [2:0]  instrLen,
  output logic        illegal
);

  ctrlStrobeT strobe;
  decT        held;

  insn_decoder_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  insn_decoder_datapath #(
    .F1_LAST_OP(F1_LAST_OP),
    .F3_LAST_OP(F3_LAST_OP)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .byteLo(byteLo),
    .byteHi(byteHi),
    .held  (held)
  );

  assign form       = held.form;
  assign opcode     = held.opcode;
  assign regA       = held.regA;
  assign regB       = held.regB;
  assign imm8       = held.imm8;
  assign brOffset   = held.brOffset;
  assign hasLongImm = held.longImm;
  assign instrLen   = held.len;
  assign illegal    = held.illegal;

endmodule

// File: rtl/insn_decoder_chk.sv
module insn_decoder_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [7:0]  byteLo,
  input logic [7:0]  byteHi,
  input logic        outValid,
  input logic [1:0]  form,
  input logic [7:0]  opcode,
  input logic [3:0]  regA,
  input logic [3:0]  regB,
  input logic [7:0]  imm8,
  input logic [31:0] brOffset,
  input logic        hasLongImm,
  input logic [2:0]  instrLen,
  input logic        illegal
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_valid_lag_R9: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> outValid == $past(inValid));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    armed && !$past(inValid) |-> $stable(opcode) && $stable(form) && $stable(brOffset) && $stable(illegal));

  assert_form_select_R2: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(inValid) |->
      form == (!$past(byteLo[7]) ? 2'd1 : ($past(byteLo[6]) ? 2'd3 : 2'd2)));

  assert_len_link_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> instrLen == (hasLongImm ? 3'd6 : 3'd2));

  assert_short_forms_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && form != 2'd1 |-> !hasLongImm);

  assert_form2_legal_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && form == 2'd2 |-> !illegal);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rstN |-> !outValid && form == 2'd0);

endmodule

bind insn_decoder insn_decoder_chk u_chk (.*);

// File: tb/tb_insn_decoder.sv
`timescale 1ns/1ps
module tb_insn_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  byteLo = '0;
  logic [7:0]  byteHi = '0;
  logic        outValid;
  logic [1:0]  form;
  logic [7:0]  opcode;
  logic [3:0]  regA, regB;
  logic [7:0]  imm8;
  logic [31:0] brOffset;
  logic        hasLongImm;
  logic [2:0]  instrLen;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  insn_decoder dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .byteLo(byteLo), .byteHi(byteHi),
    .outValid(outValid), .form(form), .opcode(opcode), .regA(regA), .regB(regB),
    .imm8(imm8), .brOffset(brOffset), .hasLongImm(hasLongImm),
    .instrLen(instrLen), .illegal(illegal)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit inLongSet(input int op);
    int s[18] = '{'h01, 'h03, 'h08, 'h09, 'h0C, 'h0D, 'h1A, 'h1B, 'h1D,
                  'h1F, 'h20, 'h22, 'h24, 'h30, 'h36, 'h37, 'h38, 'h39};
    foreach (s[k]) if (s[k] == op) return 1;
    return 0;
  endfunction

  task automatic checkWord(input int w);
    int top = w / 256;
    int lo = w % 256;
    int eForm, eOp, eA, eB, eImm, eIll, eLong;
    longint eOff;
    eOff = 0; eA = 0; eB = 0; eImm = 0; eIll = 0; eLong = 0;
    if (w < 32768) begin
      eForm = 1; eOp = top; eA = lo / 16; eB = lo % 16;
      eLong = inLongSet(top);
      eIll = (top == 0 || top > 57) ? 1 : 0;
    end else if (w < 49152) begin
      eForm = 2; eOp = (w / 4096) % 4; eA = top % 16; eImm = lo;
    end else begin
      eForm = 3; eOp = (w / 1024) % 16;
      eOff = w % 1024;
      if (eOff >= 512) eOff = eOff - 1024;
      eOff = eOff * 2;
      eIll = (eOp > 9) ? 1 : 0;
    end
    check("R2 form", form, eForm);
    if (eForm == 1)
      check("R3 layout-1 fields", {opcode, regA, regB, imm8, brOffset},
            {eOp[7:0], eA[3:0], eB[3:0], 8'h0, 32'h0});
    else if (eForm == 2)
      check("R4 layout-2 fields", {opcode, regA, regB, imm8, brOffset},
            {eOp[7:0], eA[3:0], 4'h0, eImm[7:0], 32'h0});
    else
      check("R5 layout-3 fields", {opcode, regA, regB, imm8, brOffset},
            {eOp[7:0], 4'h0, 4'h0, 8'h0, eOff[31:0]});
    if (eForm == 1)
      check("R6 long immediate and length", {hasLongImm, instrLen}, {eLong[0], eLong ? 3'd6 : 3'd2});
    else
      check("R7 short layouts", {hasLongImm, instrLen}, {1'b0, 3'd2});
    check("R8 illegal", illegal, eIll);
    check("R9 outValid", outValid, 1);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    byteLo = 8'hA5; byteHi = 8'h5A; inValid = 1'b1;
    @(negedge clk);
    // R10: reset holds everything at zero even with valid input
    check("R10 reset outValid", outValid, 0);
    check("R10 reset fields", {form, opcode, regA, regB, imm8, brOffset, hasLongImm, instrLen, illegal}, 0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", outValid, 0);

    // R1: lower-address byte lands in bits 15:8
    byteLo = 8'h01; byteHi = 8'h23; inValid = 1'b1;
    @(negedge clk);
    check("R1 byte order", {opcode, regA, regB}, {8'h01, 4'h2, 4'h3});

    for (int w = 0; w < 65536; w++) begin
      byteLo = w[15:8]; byteHi = w[7:0]; inValid = 1'b1;
      @(negedge clk);
      checkWord(w);
    end

    // R9: bytes change with valid low; fields hold decode of 0xFFFF
    inValid = 1'b0; byteLo = 8'h01; byteHi = 8'h00;
    @(negedge clk);
    check("R9 valid drops", outValid, 0);
    check("R9 fields hold", {form, opcode, brOffset, illegal, instrLen},
          {2'd3, 8'h0F, 32'hFFFF_FFFE, 1'b1, 3'd2});
    @(negedge clk);
    check("R9 still held", {form, opcode, hasLongImm}, {2'd3, 8'h0F, 1'b0});
    inValid = 1'b1;
    @(negedge clk);
    check("R9 capture resumes", {outValid, form, opcode, hasLongImm, instrLen},
          {1'b1, 2'd1, 8'h01, 1'b1, 3'd6});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule